// File: doc/BRIEF.md
# CAN Restricted Operation Mode Controller

This block controls a listen-and-acknowledge-only mode of a CAN protocol controller. In this mode the node still receives frames and acknowledges the valid ones. It never starts a frame of its own. It never drives the dominant bits of an error flag or an overload flag.

Software controls the mode bit through a write strobe and a data bit. Setting the bit is guarded: it takes effect only while both the configuration-change-enable bit and the init bit are 1. Clearing the bit is always allowed. Hardware also sets the bit when the transmit path fails to fetch frame data in time. A hardware set wins over a software clear in the same cycle.

When an error or overload condition occurs while the mode is active, the node drives nothing. It drops its bus-integration status and waits until it has sampled a run of consecutive recessive bits. Only then does it take part in the bus again. While error logging is active in this mode, the block also tells the error counters to hold their values.

Top module: `can_restricted_mode_ctrl`

## Requirements
- R1: A software write with data 1 sets the mode bit only when `cfg_en` and `init_en` are both 1. In every other case the write leaves the mode bit unchanged.
- R2: A software write with data 0 clears the mode bit on the next clock edge, whatever the values of `cfg_en` and `init_en`.
- R3: A `tx_underrun` pulse sets the mode bit on the next clock edge. The bit then stays set until a software clear.
- R4: When `tx_underrun` and a software clear arrive in the same cycle, the mode bit ends up set.
- R5: While the mode is active, `tx_bit` is 1 (recessive) in every bit that is not an acknowledge slot. While the mode is off, `tx_bit` equals `eng_tx_bit`.
- R6: While the mode is active and `bus_ready` is 1, an acknowledge slot (`eng_ack_slot`=1) passes `eng_tx_bit` through to `tx_bit`. This lets a dominant acknowledge reach the bus.
- R7: An `err_evt` or `ovl_evt` pulse while the mode is active drives `bus_ready` to 0 on the next edge. The same pulses have no effect on `bus_ready` while the mode is off.
- R8: After `bus_ready` falls, it returns to 1 on the edge of the IDLE_BITS-th (default 11) consecutive `bit_tick` on which `rx_bit` is 1. A tick that samples `rx_bit`=0 restarts the run.
- R9: While `bus_ready` is 0 and the mode is active, `tx_bit` is 1, even in an acknowledge slot.
- R10: `cnt_freeze` is 1 exactly when the mode is active and `log_active` is 1.
- R11: After reset the mode bit is 0, `bus_ready` is 1 and `cnt_freeze` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software write strobe for the mode bit |
| sw_wdata | input | 1 | Value written by software to the mode bit |
| cfg_en | input | 1 | Configuration-change-enable bit |
| init_en | input | 1 | Init bit |
| tx_underrun | input | 1 | Pulse: transmit data was not fetched in time |
| err_evt | input | 1 | Pulse: error condition from the protocol engine |
| ovl_evt | input | 1 | Pulse: overload condition from the protocol engine |
| rx_bit | input | 1 | Received bus level (1 = recessive) |
| bit_tick | input | 1 | Strobe at each bit sample point |
| eng_tx_bit | input | 1 | Bit requested by the protocol engine (0 = dominant) |
| eng_ack_slot | input | 1 | The current request is the acknowledge bit |
| log_active | input | 1 | Error logging is active |
| mode_on | output | 1 | Restricted mode bit |
| tx_bit | output | 1 | Gated transmit bit to the transceiver |
| bus_ready | output | 1 | Bus-integration status (1 = integrated) |
| cnt_freeze | output | 1 | Hold request to the error counters |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Guarded set.** Set attempts are made with only one of the two enable bits high. A design that decoded the guard with OR would enter the mode on those attempts.
- **Same-cycle collision.** An underrun pulse arrives together with a software clear. A design with the priority reversed would leave the mode bit at 0.
- **Idle run.** The bench counts ticks exactly at the idle-run boundary. First comes a run one tick short, then a dominant tick part-way through a run, then a full run. An off-by-one counter would release `bus_ready` a tick early or late. A counter that is not restarted by a dominant tick would release it too soon.
- **Acknowledge during integration.** The bench drives an acknowledge slot while integration is still in progress. A design that let acknowledge through here would drive a dominant bit before bus idle has been seen.

// File: rtl/can_restricted_mode_ctrl.sv
module can_restricted_mode_ctrl #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_wdata,
  input  logic cfg_en,
  input  logic init_en,
  input  logic tx_underrun,
  input  logic err_evt,
  input  logic ovl_evt,
  input  logic rx_bit,
  input  logic bit_tick,
  input  logic eng_tx_bit,
  input  logic eng_ack_slot,
  input  logic log_active,
  output logic mode_on,
  output logic tx_bit,
  output logic bus_ready,
  output logic cnt_freeze
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] idle_cnt;
  logic          sw_set_ok, sw_clr, fault;

  assign sw_set_ok = sw_wr & sw_wdata & cfg_en & init_en;
  assign sw_clr    = sw_wr & ~sw_wdata;
  assign fault     = mode_on & (err_evt | ovl_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        mode_on <= 1'b0;
    else if (tx_underrun || sw_set_ok) mode_on <= 1'b1;
    else if (sw_clr)                   mode_on <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b1;
      idle_cnt  <= '0;
    end else if (fault) begin
      bus_ready <= 1'b0;
      idle_cnt  <= '0;
    end else if (!bus_ready && bit_tick) begin
      if (!rx_bit) begin
        idle_cnt <= '0;
      end else if (idle_cnt == LAST) begin
        idle_cnt  <= '0;
        bus_ready <= 1'b1;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assign tx_bit     = (mode_on && (!eng_ack_slot || !bus_ready)) ? 1'b1 : eng_tx_bit;
  assign cnt_freeze = mode_on & log_active;
endmodule

module can_rom_checker (
  input logic clk,
  input logic rst_n,
  input logic sw_wr,
  input logic sw_wdata,
  input logic cfg_en,
  input logic init_en,
  input logic tx_underrun,
  input logic err_evt,
  input logic ovl_evt,
  input logic rx_bit,
  input logic bit_tick,
  input logic eng_tx_bit,
  input logic eng_ack_slot,
  input logic log_active,
  input logic mode_on,
  input logic tx_bit,
  input logic bus_ready,
  input logic cnt_freeze
);
  assert_guarded_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_wdata && !(cfg_en && init_en) && !tx_underrun && !mode_on) |=> !mode_on);

  assert_sw_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !sw_wdata && !tx_underrun) |=> !mode_on);

  assert_hw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> mode_on);

  assert_no_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && !eng_ack_slot) |-> tx_bit);

  assert_fault_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && (err_evt || ovl_evt)) |=> !bus_ready);

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ready) |-> ($past(bit_tick) && $past(rx_bit)));

  assert_quiet_integrating_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && !bus_ready) |-> tx_bit);
endmodule

bind can_restricted_mode_ctrl can_rom_checker u_chk (.*);

// File: tb/can_restricted_mode_ctrl_tb.sv
module can_restricted_mode_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_wr = 0, sw_wdata = 0, cfg_en = 0, init_en = 0, tx_underrun = 0;
  logic err_evt = 0, ovl_evt = 0, rx_bit = 1, bit_tick = 0;
  logic eng_tx_bit = 1, eng_ack_slot = 0, log_active = 0;
  logic mode_on, tx_bit, bus_ready, cnt_freeze;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_restricted_mode_ctrl u_dut (.*);

  // {sw_wr, sw_wdata, cfg_en, init_en, tx_underrun, expected mode_on}
  localparam logic [5:0] VEC [10] = '{
    6'b110000, // R1 set, no enables
    6'b111000, // R1 set, cfg only
    6'b110100, // R1 set, init only
    6'b111101, // R1 set allowed
    6'b000001, // hold
    6'b100000, // R2 clear with enables low
    6'b000011, // R3 underrun sets
    6'b000001, // R3 stays set
    6'b101111, // R4 underrun beats clear
    6'b101100  // R2 clear
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    sw_wr = 0; tx_underrun = 0; err_evt = 0; ovl_evt = 0; bit_tick = 0;
  endtask

  task automatic ticks(input int n, input logic lvl);
    for (int k = 0; k < n; k++) begin
      bit_tick = 1; rx_bit = lvl; cyc();
    end
    rx_bit = 1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 mode", mode_on, 1'b0);
    chk("R11 ready", bus_ready, 1'b1);
    chk("R11 freeze", cnt_freeze, 1'b0);
    rst_n = 1;
    @(negedge clk);
    eng_tx_bit = 0;
    #1 chk("R5 off passthrough", tx_bit, 1'b0);

    for (int i = 0; i < 10; i++) begin
      {sw_wr, sw_wdata, cfg_en, init_en, tx_underrun} = VEC[i][5:1];
      cyc();
      cfg_en = 0; init_en = 0;
      chk($sformatf("R1-4 vector %0d", i), mode_on, VEC[i][0]);
    end

    // enter mode via underrun
    tx_underrun = 1; cyc();
    eng_tx_bit = 0; eng_ack_slot = 0;
    #1 chk("R5 data gated", tx_bit, 1'b1);
    eng_ack_slot = 1;
    #1 chk("R6 ack passes", tx_bit, 1'b0);
    log_active = 1;
    #1 chk("R10 freeze on", cnt_freeze, 1'b1);
    log_active = 0;
    #1 chk("R10 freeze off", cnt_freeze, 1'b0);

    err_evt = 1; cyc();
    chk("R7 error drops ready", bus_ready, 1'b0);
    #1 chk("R9 ack blocked", tx_bit, 1'b1);
    ticks(10, 1'b1);
    chk("R8 ten recessive", bus_ready, 1'b0);
    ticks(1, 1'b0);
    ticks(10, 1'b1);
    chk("R8 restart after dominant", bus_ready, 1'b0);
    ticks(1, 1'b1);
    chk("R8 eleven recessive", bus_ready, 1'b1);

    ovl_evt = 1; cyc();
    chk("R7 overload drops ready", bus_ready, 1'b0);
    ticks(11, 1'b1);
    chk("R8 overload release", bus_ready, 1'b1);

    sw_wr = 1; sw_wdata = 0; cyc();
    chk("R2 clear", mode_on, 1'b0);
    err_evt = 1; cyc();
    chk("R7 ignored when off", bus_ready, 1'b1);
    eng_ack_slot = 0; eng_tx_bit = 0;
    #1 chk("R5 off dominant", tx_bit, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule